// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block lets a clocked host read and write a 16-bit asynchronous static RAM that has active-low chip enable, output enable, write enable and one select per byte lane. The host offers a request (word address, write data, write flag and one enable per byte lane) and holds it until the controller raises ready. Once it accepts a request, the controller sequences the memory strobes over a number of clock cycles that are set by parameters. Each parameter is sized from the clock period and the memory's nanosecond limits.

A write drives the data bus and the address first, with every byte select high. It then lowers write enable and the enabled byte selects for the strobe window. The write ends when the byte selects rise, so write enable stays low into a closing cycle. If another write arrives in that closing cycle, write enable stays low across both words and the byte selects act as the write strobes. A read lowers output enable and the enabled byte selects, samples the bus on the last cycle of the access window, and returns the word with a one-cycle valid pulse. Lanes that were not enabled come back as zero. When a read follows a write, a turnaround cycle releases the data driver before output enable falls.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte selects are high, the data driver is off, ready is high and the response valid is low.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. Ready stays low during the setup, strobe, turnaround and read-access cycles, and is high only in idle and in the closing cycle of a write.
- R3: A write from idle first spends SETUP_CYC cycles with the data driver on, the address and data applied, write enable high and both selects high. It then spends WLOW_CYC cycles with write enable and the enabled selects low, and finishes with one closing cycle in which the selects are high while write enable, address and data are held.
- R4: Byte enable bit 0 controls the lower lane (data bits 7:0, select mem_bs_n[0]). Bit 1 controls the upper lane (bits 15:8, select mem_bs_n[1]). A lane whose enable is low keeps its stored contents during a write.
- R5: A read holds output enable and the enabled selects low for RD_CYC cycles and samples the data bus on the last of them. rsp_valid is high for exactly the next cycle, and rsp_rdata carries the sampled word with the bits of every lane that was not enabled set to zero.
- R6: The data driver is never on while output enable is low, and it is off in the cycle before output enable falls.
- R7: Output enable is high in the cycle before write enable falls.
- R8: A write taken in the closing cycle of a previous write keeps write enable low. The new address and data are applied with both selects high for SETUP_CYC cycles before the selects fall.
- R9: A read taken in the closing cycle of a write first passes one turnaround cycle, in which write enable is high, the driver is off and output enable is still high.
- R10: Chip enable is low in every cycle of an access and high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_bs_n | output | 2 | Byte selects, bit 0 lower, bit 1 upper, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data read from the memory bus |
| mem_dq_oe | output | 1 | Enable of the data bus driver |

## Verification
A wrong sequencer state shows at the memory pins in the cycle after it goes wrong. The likely forms are a missing setup cycle, write enable rising before the selects, output enable falling while the driver is still on, or ready rising in the middle of an access. Per-cycle pin checks on a sequence that chains a write, a back-to-back write and a read expose these at once. Errors in lane masking or in the read sample point only show up when the word is read back. The sweep writes every address with data computed from the address, and later reads every word with full and partial lane enables, so a corrupted lane is caught on the first read of that word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WSTB  = 3'd2,
    ST_WEND  = 3'd3,
    ST_RTURN = 3'd4,
    ST_RACC  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = load_val;
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int WLOW_CYC  = 1,
  parameter int RD_CYC    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_be,
  output logic                     req_ready,
  output seq_state_t               st_nxt,
  output logic                     hold_nxt,
  output logic [ADDR_W-1:0]        addr_nxt,
  output logic [LANES*LANE_W-1:0]  wdata_nxt,
  output logic [LANES-1:0]         be_nxt,
  output logic [LANES-1:0]         be_cur,
  output logic                     rd_last
);
  localparam int MAX_AB = (SETUP_CYC > WLOW_CYC) ? SETUP_CYC : WLOW_CYC;
  localparam int MAX_C  = (MAX_AB > RD_CYC) ? MAX_AB : RD_CYC;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WLO_LD = CNT_W'(WLOW_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);

  seq_state_t st_q;
  logic hold_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES*LANE_W-1:0] wdata_q;
  logic [LANES-1:0] be_q;
  logic tm_load, tm_zero;
  logic [CNT_W-1:0] tm_val;

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .zero(tm_zero)
  );

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_WEND);

  always_comb begin
    st_nxt    = st_q;
    hold_nxt  = hold_q;
    addr_nxt  = addr_q;
    wdata_nxt = wdata_q;
    be_nxt    = be_q;
    tm_load   = 1'b0;
    tm_val    = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_nxt  = req_addr;
          wdata_nxt = req_wdata;
          be_nxt    = req_be;
          hold_nxt  = 1'b0;
          tm_load   = 1'b1;
          if (req_write) begin
            st_nxt = ST_WSET;
            tm_val = SET_LD;
          end else begin
            st_nxt = ST_RACC;
            tm_val = RD_LD;
          end
        end
      end
      ST_WSET: begin
        if (tm_zero) begin
          st_nxt  = ST_WSTB;
          tm_load = 1'b1;
          tm_val  = WLO_LD;
        end
      end
      ST_WSTB: begin
        if (tm_zero) st_nxt = ST_WEND;
      end
      ST_WEND: begin
        if (req_valid) begin
          addr_nxt  = req_addr;
          wdata_nxt = req_wdata;
          be_nxt    = req_be;
          if (req_write) begin
            st_nxt   = ST_WSET;
            hold_nxt = 1'b1;
            tm_load  = 1'b1;
            tm_val   = SET_LD;
          end else begin
            st_nxt   = ST_RTURN;
            hold_nxt = 1'b0;
          end
        end else begin
          st_nxt   = ST_IDLE;
          hold_nxt = 1'b0;
        end
      end
      ST_RTURN: begin
        st_nxt  = ST_RACC;
        tm_load = 1'b1;
        tm_val  = RD_LD;
      end
      ST_RACC: begin
        if (tm_zero) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hold_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      st_q    <= st_nxt;
      hold_q  <= hold_nxt;
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
      be_q    <= be_nxt;
    end
  end

  assign be_cur  = be_q;
  assign rd_last = (st_q == ST_RACC) && tm_zero;

  // R2: an offered request in idle always leaves idle
  assert_take_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_valid) |=> (st_q != ST_IDLE));
  // R9: turnaround is always followed by the read access
  assert_turn_then_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RTURN) |=> (st_q == ST_RACC));
endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seq_state_t               st_nxt,
  input  logic                     hold_nxt,
  input  logic [ADDR_W-1:0]        addr_nxt,
  input  logic [LANES*LANE_W-1:0]  wdata_nxt,
  input  logic [LANES-1:0]         be_nxt,
  input  logic [LANES-1:0]         be_cur,
  input  logic                     rd_last,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in,
  output logic                     mem_ce_n,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [LANES-1:0]         mem_bs_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_oe,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata
);
  localparam int DATA_W = LANES * LANE_W;

  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d, strobe_d;
  logic [LANES-1:0] bs_n_d;
  logic [DATA_W-1:0] rd_masked;

  always_comb begin
    ce_n_d   = (st_nxt == ST_IDLE);
    oe_n_d   = (st_nxt != ST_RACC);
    we_n_d   = !((st_nxt == ST_WSTB) || (st_nxt == ST_WEND) ||
                 ((st_nxt == ST_WSET) && hold_nxt));
    dq_oe_d  = (st_nxt == ST_WSET) || (st_nxt == ST_WSTB) || (st_nxt == ST_WEND);
    strobe_d = (st_nxt == ST_WSTB) || (st_nxt == ST_RACC);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bs_n_d[l] = !(strobe_d && be_nxt[l]);
    assign rd_masked[l*LANE_W +: LANE_W] =
      be_cur[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_bs_n   <= '1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      mem_ce_n   <= ce_n_d;
      mem_oe_n   <= oe_n_d;
      mem_we_n   <= we_n_d;
      mem_bs_n   <= bs_n_d;
      mem_dq_oe  <= dq_oe_d;
      mem_addr   <= addr_nxt;
      mem_dq_out <= wdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_last;
      if (rd_last) rsp_rdata <= rd_masked;
    end
  end

  // R6: driver and memory output never on together
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  // R6: driver already released the cycle before output enable falls
  assert_release_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  // R7: output enable high before write enable falls
  assert_oe_before_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));
  // R3: a write overlap only happens with the data driven
  assert_overlap_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n && (mem_bs_n != '1)) |-> mem_dq_oe);
  // R5: response valid is a single-cycle pulse
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: chip enable is low while any strobe is active
  assert_ce_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int SETUP_CYC = 1,
  parameter int WLOW_CYC  = 1,
  parameter int RD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_bs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int LANES  = 2;
  localparam int LANE_W = 8;

  seq_state_t st_nxt;
  logic hold_nxt, rd_last;
  logic [ADDR_W-1:0] addr_nxt;
  logic [15:0] wdata_nxt;
  logic [1:0] be_nxt, be_cur;

  sram_lane_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W),
    .SETUP_CYC(SETUP_CYC), .WLOW_CYC(WLOW_CYC), .RD_CYC(RD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .st_nxt(st_nxt), .hold_nxt(hold_nxt), .addr_nxt(addr_nxt),
    .wdata_nxt(wdata_nxt), .be_nxt(be_nxt), .be_cur(be_cur), .rd_last(rd_last)
  );

  sram_lane_pins #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .st_nxt(st_nxt), .hold_nxt(hold_nxt), .addr_nxt(addr_nxt),
    .wdata_nxt(wdata_nxt), .be_nxt(be_nxt), .be_cur(be_cur), .rd_last(rd_last),
    .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int AW    = 5;
  localparam int WORDS = 1 << AW;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0] req_be;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_bs_n;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk, n_bad;
  logic [15:0] store [WORDS];
  logic [15:0] expect_mem [WORDS];
  logic prev_oe_n, prev_dq_oe, prev_we_n;

  sram_lane_ctrl #(.ADDR_W(AW), .SETUP_CYC(1), .WLOW_CYC(1), .RD_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: unselected lanes read back as A5
  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_bs_n[0]) mem_dq_in[7:0]  = store[mem_addr][7:0];
      if (!mem_bs_n[1]) mem_dq_in[15:8] = store[mem_addr][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n && mem_bs_n != 2'b11) begin
        if (!mem_dq_oe) chk(1'b0, "R3 write overlap without driver", 0, 1);
        if (!mem_bs_n[0]) store[mem_addr][7:0]  <= mem_dq_out[7:0];
        if (!mem_bs_n[1]) store[mem_addr][15:8] <= mem_dq_out[15:8];
      end
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R6 contention", 1, 0);
      if (prev_oe_n && !mem_oe_n && prev_dq_oe) chk(1'b0, "R6 driver not released", 1, 0);
      if (prev_we_n && !mem_we_n && !prev_oe_n) chk(1'b0, "R7 oe low before we fell", 0, 1);
    end
    prev_oe_n  <= mem_oe_n;
    prev_dq_oe <= mem_dq_oe;
    prev_we_n  <= mem_we_n;
  end

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  task automatic wr(input int a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'(a); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (be[0]) expect_mem[a][7:0]  = d[7:0];
    if (be[1]) expect_mem[a][15:8] = d[15:8];
  endtask

  task automatic rd(input int a, input logic [1:0] be, input string tag);
    logic [15:0] e;
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = AW'(a); req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rsp_valid && k < 20) begin @(negedge clk); k++; end
    e = {be[1] ? expect_mem[a][15:8] : 8'h00, be[0] ? expect_mem[a][7:0] : 8'h00};
    chk(rsp_valid && rsp_rdata == e, tag, {15'd0, rsp_valid, rsp_rdata}, {16'h0001, e});
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    for (int i = 0; i < WORDS; i++) begin store[i] = '0; expect_mem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
        "R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, req_ready, rsp_valid},
        8'b11111010);

    // directed: write, back-to-back write, read after write
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd3; req_wdata = 16'h1234; req_be = 2'b01;
    @(negedge clk); // setup cycle
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, req_ready} == 7'b0111110,
        "R3 setup pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe, req_ready}, 7'b0111110);
    chk(mem_addr == 5'd3 && mem_dq_out == 16'h1234, "R3 setup addr/data",
        {mem_addr, mem_dq_out}, {5'd3, 16'h1234});
    expect_mem[3][7:0] = 8'h34;
    req_addr = 5'd4; req_wdata = 16'hBEEF; req_be = 2'b10;
    @(negedge clk); // strobe
    chk({mem_we_n, mem_bs_n, req_ready} == 4'b0100, "R4 strobe lower lane only",
        {mem_we_n, mem_bs_n, req_ready}, 4'b0100);
    @(negedge clk); // closing cycle
    chk({mem_we_n, mem_bs_n, mem_dq_oe, req_ready} == 5'b01111, "R3 closing cycle",
        {mem_we_n, mem_bs_n, mem_dq_oe, req_ready}, 5'b01111);
    @(negedge clk); // back-to-back setup
    chk({mem_we_n, mem_bs_n, mem_addr} == {3'b011, 5'd4} && mem_dq_out == 16'hBEEF,
        "R8 we held low, selects high", {mem_we_n, mem_bs_n, mem_addr}, {3'b011, 5'd4});
    expect_mem[4][15:8] = 8'hBE;
    req_write = 1'b0; req_addr = 5'd3; req_be = 2'b11;
    @(negedge clk); // strobe upper
    chk({mem_we_n, mem_bs_n} == 3'b001, "R8 upper strobe", {mem_we_n, mem_bs_n}, 3'b001);
    @(negedge clk); // closing, read taken
    chk(req_ready == 1'b1, "R2 ready in closing cycle", req_ready, 1);
    @(negedge clk); // turnaround
    req_valid = 1'b0;
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready} == 5'b01100, "R9 turnaround",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b01100);
    @(negedge clk);
    chk({mem_oe_n, mem_bs_n, mem_addr, req_ready} == {3'b000, 5'd3, 1'b0}, "R5 read access 1",
        {mem_oe_n, mem_bs_n, mem_addr, req_ready}, {3'b000, 5'd3, 1'b0});
    @(negedge clk);
    chk({mem_oe_n, rsp_valid} == 2'b00, "R5 read access 2", {mem_oe_n, rsp_valid}, 0);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 16'h0034 && mem_ce_n, "R5 R10 read data and idle",
        {rsp_valid, mem_ce_n, rsp_rdata}, {2'b11, 16'h0034});
    @(negedge clk);
    chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);

    // full-word sweep with back-to-back writes
    for (int a = 0; a < WORDS; a++) wr(a, 16'(a * 16'h0123) ^ 16'h5A00, 2'b11);
    @(negedge clk) req_valid = 1'b0;
    for (int a = 0; a < WORDS; a++) rd(a, 2'b11, "R3 R8 full word readback");
    // partial-lane sweep
    for (int a = 0; a < WORDS; a++) wr(a, ~(16'(a) * 16'h0707), 2'(a % 4));
    @(negedge clk) req_valid = 1'b0;
    for (int a = 0; a < WORDS; a++) rd(a, 2'b11, "R4 partial lane readback");
    // masked reads
    for (int a = 0; a < WORDS; a += 3) begin
      rd(a, 2'b01, "R5 lower-only read");
      rd(a, 2'b10, "R5 upper-only read");
    end
    // write then read without idle gap
    wr(7, 16'hC3C3, 2'b11);
    rd(7, 2'b11, "R9 read after write");
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R10 idle after access",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    finish_run();
  end
endmodule